// File: doc/BRIEF.md
# Square QAM Constellation Mapper

This block turns a group of data bits into the I and Q coordinates of one point of a square QAM constellation. The symbol width is a parameter, so a single source covers 4-, 16-, 64- and 256-point constellations and larger square ones. Elaboration-time switches choose the ordering along each axis (straight binary, or a label passed through a binary-to-Gray step) and the output scaling (odd integer levels, or signed fixed-point values with two integer bits scaled to an average symbol power of one).

The mapping itself is pure combinational logic built from a small constant level table per axis. Symbols enter and leave on a valid/ready stream. In the unregistered build the stream passes straight through: output valid follows input valid, and input ready follows output ready. In the registered build one output register holds the mapped point. A symbol is accepted on any clock edge where in_valid and in_ready are both high, and in_ready is high whenever the register is empty or the consumer is taking the current point. While out_valid is high and out_ready is low, the held point does not change and no new symbol is accepted.

Top module: `qam_mapper`

## Requirements
- R1: The upper SYM_BITS/2 bits of in_sym form the I-axis label and the lower SYM_BITS/2 bits form the Q-axis label; in binary ordering (GRAY=0) the axis position equals the label.
- R2: With NORMALIZE=0, an axis at position p among L = 2^(SYM_BITS/2) positions outputs the integer 2p-(L-1) in two's complement, so every level is odd and adjacent levels differ by 2.
- R3: With GRAY=1, the axis position is label XOR (label >> 1), with the level rule otherwise unchanged.
- R4: With NORMALIZE=1, each coordinate equals the integer level times sqrt(3/(2(M-1))), with M = 2^SYM_BITS, coded as signed fixed point with OUT_W-OUT_INT fraction bits and rounded to nearest, so it lies within one LSB of the ideal value.
- R5: With NORMALIZE=1, the mean of I^2+Q^2 over all M symbols is 1 within 1e-4.
- R6: With REG_OUT=0, out_valid equals in_valid, in_ready equals out_ready, and out_i/out_q reflect in_sym in the same cycle.
- R7: With REG_OUT=1, in_ready equals (!out_valid || out_ready); a symbol accepted on a rising edge appears on out_i/out_q with out_valid high after that edge, and out_valid drops after an edge where the point is taken and no symbol is accepted.
- R8: With REG_OUT=1, while out_valid is high and out_ready is low, out_valid, out_i and out_q hold their values.
- R9: With REG_OUT=1, a synchronous active-low reset clears out_valid, leaving in_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input symbol present |
| in_ready | output | 1 | Block can take the input symbol |
| in_sym | input | SYM_BITS | Symbol bits, I label on top, Q label below |
| out_valid | output | 1 | Output point present |
| out_ready | input | 1 | Consumer takes the output point |
| out_i | output | OUT_W | In-phase coordinate, signed |
| out_q | output | OUT_W | Quadrature coordinate, signed |

## Verification
The bench builds three copies side by side. One is a registered 16-point build with Gray ordering and unit-power scaling, which reaches the reset state, the acceptance and drain rules and a stalled output under back-pressure while sweeping every Gray label. One is an unregistered 256-point build with binary ordering and scaling, which allows the one-LSB error bound and the average-power bound to be checked over the largest default order. One is an unregistered 64-point integer build, where every odd level and the bit split are compared exactly.

// File: rtl/qam_pkg.sv
package qam_pkg;

  // Integer level for axis position pos among side positions.
  function automatic int axis_level(input int pos, input int side);
    return 2 * pos - (side - 1);
  endfunction

  // Fixed-point code of a level scaled to unit average power.
  function automatic int unit_power_code(input int level, input int side, input int frac);
    real pts;
    real gain;
    real mag;
    int  code;
    pts  = real'(side) * real'(side);
    gain = $sqrt(3.0 / (2.0 * (pts - 1.0)));
    mag  = real'((level < 0) ? -level : level) * gain * (2.0 ** frac);
    code = $rtoi(mag + 0.5);
    return (level < 0) ? -code : code;
  endfunction

endpackage

// File: rtl/qam_level_rom.sv
module qam_level_rom #(
  parameter int SIDE_BITS = 2,
  parameter int OUT_W     = 20,
  parameter int FRAC      = 18,
  parameter bit NORMALIZE = 1'b1
) (
  input  logic [SIDE_BITS-1:0]    pos,
  output logic signed [OUT_W-1:0] coord
);
  import qam_pkg::*;

  localparam int SIDE = 1 << SIDE_BITS;

  logic signed [OUT_W-1:0] level_tab [SIDE];

  for (genvar k = 0; k < SIDE; k++) begin : g_lvl
    localparam int LVL  = axis_level(k, SIDE);
    localparam int CODE = NORMALIZE ? unit_power_code(LVL, SIDE, FRAC) : LVL;
    assign level_tab[k] = OUT_W'(CODE);
  end

  assign coord = level_tab[pos];

endmodule

// File: rtl/qam_axis_map.sv
module qam_axis_map #(
  parameter int SIDE_BITS = 2,
  parameter bit GRAY      = 1'b0,
  parameter int OUT_W     = 20,
  parameter int FRAC      = 18,
  parameter bit NORMALIZE = 1'b1
) (
  input  logic [SIDE_BITS-1:0]    label,
  output logic signed [OUT_W-1:0] coord
);
  logic [SIDE_BITS-1:0] pos;

  if (GRAY) begin : g_gray
    assign pos = label ^ (label >> 1);
  end else begin : g_bin
    assign pos = label;
  end

  qam_level_rom #(
    .SIDE_BITS (SIDE_BITS),
    .OUT_W     (OUT_W),
    .FRAC      (FRAC),
    .NORMALIZE (NORMALIZE)
  ) u_rom (
    .pos   (pos),
    .coord (coord)
  );

endmodule

// File: rtl/qam_out_stage.sv
module qam_out_stage #(
  parameter int OUT_W   = 20,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [OUT_W-1:0] i_d,
  input  logic signed [OUT_W-1:0] q_d,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);
  if (REG_OUT) begin : g_reg
    logic                    full;
    logic signed [OUT_W-1:0] i_r;
    logic signed [OUT_W-1:0] q_r;
    logic                    take;

    assign in_ready = !full || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        full <= 1'b0;
      end else if (take) begin
        full <= 1'b1;
      end else if (out_ready) begin
        full <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (take) begin
        i_r <= i_d;
        q_r <= q_d;
      end
    end

    assign out_valid = full;
    assign out_i     = i_r;
    assign out_q     = q_r;
  end else begin : g_pass
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign out_valid  = in_valid;
    assign in_ready   = out_ready;
    assign out_i      = i_d;
    assign out_q      = q_d;
  end

endmodule

// File: rtl/qam_mapper.sv
module qam_mapper #(
  parameter int SYM_BITS  = 4,
  parameter bit GRAY      = 1'b0,
  parameter bit NORMALIZE = 1'b1,
  parameter bit REG_OUT   = 1'b1,
  parameter int OUT_W     = 20,
  parameter int OUT_INT   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [SYM_BITS-1:0]     in_sym,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);
  localparam int SIDE_BITS = SYM_BITS / 2;
  localparam int FRAC      = OUT_W - OUT_INT;

  logic [SIDE_BITS-1:0]    lab_i;
  logic [SIDE_BITS-1:0]    lab_q;
  logic signed [OUT_W-1:0] map_i;
  logic signed [OUT_W-1:0] map_q;

  assign lab_i = in_sym[SYM_BITS-1 -: SIDE_BITS];
  assign lab_q = in_sym[SIDE_BITS-1:0];

  qam_axis_map #(
    .SIDE_BITS (SIDE_BITS), .GRAY (GRAY), .OUT_W (OUT_W),
    .FRAC (FRAC), .NORMALIZE (NORMALIZE)
  ) u_axis_i (
    .label (lab_i),
    .coord (map_i)
  );

  qam_axis_map #(
    .SIDE_BITS (SIDE_BITS), .GRAY (GRAY), .OUT_W (OUT_W),
    .FRAC (FRAC), .NORMALIZE (NORMALIZE)
  ) u_axis_q (
    .label (lab_q),
    .coord (map_q)
  );

  qam_out_stage #(
    .OUT_W   (OUT_W),
    .REG_OUT (REG_OUT)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .i_d       (map_i),
    .q_d       (map_q),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_i     (out_i),
    .out_q     (out_q)
  );

endmodule

// File: rtl/qam_mapper_chk.sv
module qam_mapper_chk #(
  parameter int SYM_BITS  = 4,
  parameter bit NORMALIZE = 1'b1,
  parameter bit REG_OUT   = 1'b1,
  parameter int OUT_W     = 20
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [OUT_W-1:0] out_i,
  input logic signed [OUT_W-1:0] out_q
);
  localparam int TOP = (1 << (SYM_BITS / 2)) - 1;

  if (REG_OUT) begin : g_reg
    a_r7_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready == (!out_valid || out_ready));
    a_r7_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q)));
  end else begin : g_pass
    a_r6_stream_through: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == in_valid) && (in_ready == out_ready));
  end

  if (!NORMALIZE) begin : g_int
    a_r2_odd_levels: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_i[0] && out_q[0]));
    a_r2_level_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($signed(out_i) <= TOP && $signed(out_i) >= -TOP &&
                     $signed(out_q) <= TOP && $signed(out_q) >= -TOP));
  end

endmodule

bind qam_mapper qam_mapper_chk #(
  .SYM_BITS  (SYM_BITS),
  .NORMALIZE (NORMALIZE),
  .REG_OUT   (REG_OUT),
  .OUT_W     (OUT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_i     (out_i),
  .out_q     (out_q)
);

// File: tb/sim_qam_mapper.sv
module sim_qam_mapper;
  localparam int W    = 20;
  localparam int FRAC = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // u0: 16 points, Gray, unit power, registered
  logic       v0 = 1'b0, r0 = 1'b1, rdy0, ov0;
  logic [3:0] s0 = '0;
  logic signed [W-1:0] i0, q0;
  qam_mapper #(.SYM_BITS(4), .GRAY(1'b1), .NORMALIZE(1'b1), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(v0), .in_ready(rdy0), .in_sym(s0),
    .out_valid(ov0), .out_ready(r0), .out_i(i0), .out_q(q0));

  // u1: 256 points, binary, unit power, pass-through
  logic       v1 = 1'b0, r1 = 1'b0, rdy1, ov1;
  logic [7:0] s1 = '0;
  logic signed [W-1:0] i1, q1;
  qam_mapper #(.SYM_BITS(8), .GRAY(1'b0), .NORMALIZE(1'b1), .REG_OUT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_ready(rdy1), .in_sym(s1),
    .out_valid(ov1), .out_ready(r1), .out_i(i1), .out_q(q1));

  // u2: 64 points, binary, integer levels, pass-through
  logic       v2 = 1'b1, r2 = 1'b1, rdy2, ov2;
  logic [5:0] s2 = '0;
  logic signed [W-1:0] i2, q2;
  qam_mapper #(.SYM_BITS(6), .GRAY(1'b0), .NORMALIZE(1'b0), .REG_OUT(1'b0)) u2 (
    .clk(clk), .rst_n(rst_n), .in_valid(v2), .in_ready(rdy2), .in_sym(s2),
    .out_valid(ov2), .out_ready(r2), .out_i(i2), .out_q(q2));

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_near(input string req, input int act, input real ideal);
    n_chk++;
    if ((real'(act) - ideal > 1.0) || (ideal - real'(act) > 1.0)) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %f", req, act, ideal);
    end
  endtask

  // Ideal level for a label, from R1-style split, R2 levels and R3 ordering.
  function automatic int ideal_level(input int side_bits, input bit gray, input int label);
    int pos;
    pos = gray ? (label ^ (label >> 1)) : label;
    return 2 * pos - ((1 << side_bits) - 1);
  endfunction

  function automatic real ideal_scaled(input int side_bits, input int lvl);
    real m;
    m = real'(1 << (2 * side_bits));
    return real'(lvl) * $sqrt(3.0 / (2.0 * (m - 1.0))) * (2.0 ** FRAC);
  endfunction

  initial begin
    real pwr;
    // R9: reset state of the registered build
    repeat (3) @(negedge clk);
    check_eq("R9 out_valid in reset", int'(ov0), 0);
    check_eq("R9 in_ready in reset", int'(rdy0), 1);
    rst_n = 1'b1;

    // R3/R4/R7: sweep every Gray label through the register
    for (int s = 0; s < 16; s++) begin
      v0 = 1'b1; s0 = 4'(s);
      @(negedge clk);
      check_eq("R7 out_valid after accept", int'(ov0), 1);
      check_near("R3 R4 gray I", int'(i0), ideal_scaled(2, ideal_level(2, 1'b1, s >> 2)));
      check_near("R3 R4 gray Q", int'(q0), ideal_scaled(2, ideal_level(2, 1'b1, s & 3)));
    end
    v0 = 1'b0;
    @(negedge clk);
    check_eq("R7 drain out_valid", int'(ov0), 0);

    // R7/R8: back-pressure
    v0 = 1'b1; s0 = 4'd5; r0 = 1'b0;
    @(negedge clk);
    check_eq("R7 held valid", int'(ov0), 1);
    check_eq("R7 in_ready low while stalled", int'(rdy0), 0);
    s0 = 4'd9;
    repeat (2) @(negedge clk);
    check_eq("R8 valid held", int'(ov0), 1);
    check_near("R8 I held", int'(i0), ideal_scaled(2, ideal_level(2, 1'b1, 1)));
    check_near("R8 Q held", int'(q0), ideal_scaled(2, ideal_level(2, 1'b1, 1)));
    r0 = 1'b1;
    #1;
    check_eq("R7 in_ready when taken", int'(rdy0), 1);
    @(negedge clk);
    check_near("R7 next point I", int'(i0), ideal_scaled(2, ideal_level(2, 1'b1, 2)));
    check_near("R7 next point Q", int'(q0), ideal_scaled(2, ideal_level(2, 1'b1, 1)));
    v0 = 1'b0;

    // R6: pass-through handshake combinations
    for (int c = 0; c < 4; c++) begin
      v1 = c[0]; r1 = c[1];
      #1;
      check_eq("R6 out_valid follows in_valid", int'(ov1), c & 1);
      check_eq("R6 in_ready follows out_ready", int'(rdy1), (c >> 1) & 1);
    end

    // R1/R4/R5: all 256 binary points, same-cycle, plus mean power
    pwr = 0.0;
    for (int s = 0; s < 256; s++) begin
      s1 = 8'(s);
      #1;
      check_near("R1 R4 R6 I", int'(i1), ideal_scaled(4, ideal_level(4, 1'b0, s >> 4)));
      check_near("R1 R4 R6 Q", int'(q1), ideal_scaled(4, ideal_level(4, 1'b0, s & 15)));
      pwr += (real'(int'(i1)) ** 2 + real'(int'(q1)) ** 2) / (2.0 ** (2 * FRAC));
    end
    pwr = pwr / 256.0;
    n_chk++;
    if (pwr - 1.0 > 1e-4 || 1.0 - pwr > 1e-4) begin
      n_fail++;
      $display("FAIL R5 mean power: actual %f expected 1.0", pwr);
    end

    // R1/R2: all 64 integer points exactly
    for (int s = 0; s < 64; s++) begin
      s2 = 6'(s);
      #1;
      check_eq("R1 R2 integer I", int'(i2), ideal_level(3, 1'b0, s >> 3));
      check_eq("R1 R2 integer Q", int'(q2), ideal_level(3, 1'b0, s & 7));
    end

    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule